// File: doc/BRIEF.md
# Two-Channel Bus-Master Word Mover

This block moves 32-bit words between local memory and a PCI master port on behalf of a CPU-side host bridge. Software programs one of two channels through a small word-addressed register port. Each channel holds a control word, a PCI start address and a local-memory start address. Writing the control word so that its start bit goes from 0 to 1 launches a transfer. A single shared set of working registers then walks both addresses upward, one word at a time, until the remaining-word count reaches zero.

Every word goes through two valid/ready handshakes. The engine first reads the source port, holds the returned word, then writes it to the destination port. The direction bit picks which side is the source. A separate bit chooses PCI memory space or PCI IO space. Once a transfer is finished, software reads the channel's control word, and that read clears the busy and start bits. If the channel's interrupt-enable bit was set, a per-channel done flag is raised, and software clears it by writing a 1 to it.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, every register reads 0, `mem_valid` and `pci_valid` are low, and `done_flag` is 0.
- R2: A transfer starts when a control write changes the start bit (bit 28) from 0 to 1, with bit 31 of the written value clear, while the engine is idle. On that start the current PCI address (index 8) and the current memory address (index 7) take the channel's base registers. The remaining count (index 6) takes the size field (bits 19:0) shifted right by 2. Busy (bit 31) is set in that control word. A size below 4 bytes gives a count of 0, and no bus access follows.
- R3: No transfer starts when the written control value has bit 31 set, or when the start bit was already 1 before the write.
- R4: With bit 29 set, each word is read from the PCI port and written to the memory port. With bit 29 clear, each word is read from memory and written to PCI. The write carries the word that was read.
- R5: `pci_io` is high (IO space) when bit 25 of the active control word is 0, and low (memory space) when bit 25 is 1.
- R6: The engine waits for `ready` on the read before it issues the write. It updates the counters only after the write is accepted. It then adds 4 to both addresses and subtracts 1 from the count. It stops once the count reaches 0, and it holds each request stable while `ready` is low.
- R7: Reading a control word while the remaining count is 0 returns the current value and then clears its busy and start bits. A read while the count is nonzero changes nothing.
- R8: Only one transfer runs at a time. A start edge on another channel during a transfer is ignored, and that channel's busy bit stays clear.
- R9: When a transfer completes with bit 30 set, `done_flag[ch]` rises. Writing 1 to bit ch of index 9 clears it. Nothing is raised when bit 30 is clear.
- R10: Register indices are: channel c control at 3c, PCI base at 3c+1 and memory base at 3c+2. The shared registers follow: remaining count at 6, current memory address at 7, current PCI address at 8, done flags at 9. Base registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | RA_W | Register word index |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational from `cpu_addr`) |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts request / read data valid |
| mem_rdata | input | 32 | Memory read data |
| pci_valid | output | 1 | PCI request valid |
| pci_write | output | 1 | PCI request is a write |
| pci_io | output | 1 | 1 = IO space, 0 = memory space |
| pci_addr | output | AW | PCI byte address |
| pci_wdata | output | 32 | PCI write data |
| pci_ready | input | 1 | PCI accepts request / read data valid |
| pci_rdata | input | 32 | PCI read data |
| done_flag | output | NUM_CH | Per-channel completion flags |

## Verification
The embedded properties assume a few things about the environment. A master port drives `ready` only while its request is valid, and read data is valid in the same cycle as `ready`. The CPU port makes at most one access per cycle. The bench meets these assumptions by raising `ready` for exactly one cycle, only after it has seen the matching `valid`, and by issuing one register access at a time, spaced a full clock apart. Stall cycles on the write side exercise the hold-while-not-ready property and the rule that counters freeze until the write is accepted.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   // control word bit positions (software decodes these)
   localparam int CTL_BUSY = 31;
   localparam int CTL_IE   = 30;
   localparam int CTL_DIR  = 29;
   localparam int CTL_GO   = 28;
   localparam int CTL_SUSP = 27;
   localparam int CTL_INC  = 26;
   localparam int CTL_MIO  = 25;
   localparam int CTL_RST  = 24;

   // register layout
   localparam int REGS_PER_CH = 3;
   localparam int OFF_CTRL    = 0;
   localparam int OFF_PBASE   = 1;
   localparam int OFF_MBASE   = 2;
   localparam int SH_REM      = 0;
   localparam int SH_CMEM     = 1;
   localparam int SH_CPCI     = 2;
   localparam int SH_DONE     = 3;
   localparam int SH_COUNT    = 4;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_READ  = 2'd1,
      MV_WRITE = 2'd2
   } mv_state_e;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
#(
   parameter int AW     = 32,
   parameter int SIZE_W = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ctrl,
   input  logic          wr_pbase,
   input  logic          wr_mbase,
   input  logic [31:0]   wdata,
   input  logic          set_busy,
   input  logic          rd_clear,
   output logic          go_rise,
   output logic [31:0]   ctrl_q,
   output logic [AW-1:0] pbase_q,
   output logic [AW-1:0] mbase_q
);
   localparam logic [31:0] SIZE_MASK = 32'((64'd1 << SIZE_W) - 64'd1);
   localparam logic [31:0] WMASK     = 32'h7F00_0000 | SIZE_MASK;

   // a start edge needs GO 0->1 with busy clear in the written value
   assign go_rise = wr_ctrl && !ctrl_q[CTL_GO] && wdata[CTL_GO] && !wdata[CTL_BUSY];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pbase_q <= '0;
         mbase_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q           <= (wdata & WMASK) | (ctrl_q & (32'd1 << CTL_BUSY));
            if (set_busy)
               ctrl_q[CTL_BUSY] <= 1'b1;
         end else if (rd_clear) begin
            ctrl_q[CTL_BUSY] <= 1'b0;
            ctrl_q[CTL_GO]   <= 1'b0;
         end
         if (wr_pbase) pbase_q <= wdata[AW-1:0];
         if (wr_mbase) mbase_q <= wdata[AW-1:0];
      end
   end

   assert_busy_rise_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q[CTL_BUSY]) |-> $past(set_busy));
   assert_busy_fall_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[CTL_BUSY]) |-> $past(rd_clear));
endmodule

// File: rtl/bmdma_mover.sv
module bmdma_mover
   import bmdma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = 18,
   parameter int CH_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CH_W-1:0]  start_ch,
   input  logic             start_dir,
   input  logic             start_mio,
   input  logic [AW-1:0]    start_pci,
   input  logic [AW-1:0]    start_mem,
   input  logic [CNT_W-1:0] start_cnt,
   output logic             idle,
   output logic             done,
   output logic [CH_W-1:0]  done_ch,
   output logic [CNT_W-1:0] rem_q,
   output logic [AW-1:0]    cur_pci_q,
   output logic [AW-1:0]    cur_mem_q,
   output logic             mem_valid,
   output logic             mem_write,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ready,
   input  logic [31:0]      mem_rdata,
   output logic             pci_valid,
   output logic             pci_write,
   output logic             pci_io,
   output logic [AW-1:0]    pci_addr,
   output logic [31:0]      pci_wdata,
   input  logic             pci_ready,
   input  logic [31:0]      pci_rdata
);
   localparam logic [AW-1:0]    STEP = AW'(4);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   mv_state_e        state;
   logic             dir_q, mio_q, done_q;
   logic [CH_W-1:0]  ch_q;
   logic [31:0]      data_q;
   logic             src_ready, dst_ready;
   logic [31:0]      src_rdata;

   // source is PCI when dir is set, memory otherwise
   assign src_ready = dir_q ? pci_ready : mem_ready;
   assign dst_ready = dir_q ? mem_ready : pci_ready;
   assign src_rdata = dir_q ? pci_rdata : mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= MV_IDLE;
         dir_q     <= 1'b0;
         mio_q     <= 1'b0;
         done_q    <= 1'b0;
         ch_q      <= '0;
         data_q    <= '0;
         rem_q     <= '0;
         cur_pci_q <= '0;
         cur_mem_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            MV_IDLE: begin
               if (start) begin
                  ch_q      <= start_ch;
                  dir_q     <= start_dir;
                  mio_q     <= start_mio;
                  cur_pci_q <= start_pci;
                  cur_mem_q <= start_mem;
                  rem_q     <= start_cnt;
                  if (start_cnt == '0) done_q <= 1'b1;
                  else                 state  <= MV_READ;
               end
            end
            MV_READ: begin
               if (src_ready) begin
                  data_q <= src_rdata;
                  state  <= MV_WRITE;
               end
            end
            MV_WRITE: begin
               if (dst_ready) begin
                  cur_pci_q <= cur_pci_q + STEP;
                  cur_mem_q <= cur_mem_q + STEP;
                  rem_q     <= rem_q - ONE;
                  if (rem_q == ONE) begin
                     state  <= MV_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     state <= MV_READ;
                  end
               end
            end
            default: state <= MV_IDLE;
         endcase
      end
   end

   assign idle    = (state == MV_IDLE);
   assign done    = done_q;
   assign done_ch = ch_q;

   assign mem_valid = ((state == MV_READ) && !dir_q) || ((state == MV_WRITE) && dir_q);
   assign pci_valid = ((state == MV_READ) && dir_q) || ((state == MV_WRITE) && !dir_q);
   assign mem_write = (state == MV_WRITE);
   assign pci_write = (state == MV_WRITE);
   assign mem_addr  = cur_mem_q;
   assign pci_addr  = cur_pci_q;
   assign mem_wdata = data_q;
   assign pci_wdata = data_q;
   assign pci_io    = !mio_q;

   assert_hold_mem_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
   assert_hold_pci_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (pci_valid && !pci_ready) |=> (pci_valid && $stable(pci_addr) && $stable(pci_io)));
   assert_rem_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q != $past(rem_q)) |-> ($past(start) || (rem_q == $past(rem_q) - ONE)));
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
   import bmdma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int AW     = 32,
   parameter int SIZE_W = 20,
   parameter int RA_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [RA_W-1:0]   cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              pci_valid,
   output logic              pci_write,
   output logic              pci_io,
   output logic [AW-1:0]     pci_addr,
   output logic [31:0]       pci_wdata,
   input  logic              pci_ready,
   input  logic [31:0]       pci_rdata,
   output logic [NUM_CH-1:0] done_flag
);
   localparam int CNT_W   = SIZE_W - 2;
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int SH_BASE = NUM_CH * REGS_PER_CH;

   localparam logic [RA_W-1:0] A_REM  = RA_W'(SH_BASE + SH_REM);
   localparam logic [RA_W-1:0] A_CMEM = RA_W'(SH_BASE + SH_CMEM);
   localparam logic [RA_W-1:0] A_CPCI = RA_W'(SH_BASE + SH_CPCI);
   localparam logic [RA_W-1:0] A_DONE = RA_W'(SH_BASE + SH_DONE);

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1 || SH_BASE + SH_COUNT > (1 << RA_W))
         $error("bmdma_engine: NUM_CH does not fit in RA_W address bits");
      if (SIZE_W < 3 || SIZE_W > 24)
         $error("bmdma_engine: SIZE_W must lie in 3..24");
      if (AW < 3 || AW > 32)
         $error("bmdma_engine: AW must lie in 3..32");
   endgenerate

   logic              rd_acc, wr_acc;
   logic [NUM_CH-1:0] wr_ctrl, wr_pbase, wr_mbase, rd_ctrl;
   logic [NUM_CH-1:0] go_rise, set_busy, rd_clear;
   logic [31:0]       ctrl_q  [NUM_CH];
   logic [AW-1:0]     pbase_q [NUM_CH];
   logic [AW-1:0]     mbase_q [NUM_CH];

   logic              mv_idle, mv_done, start;
   logic [CH_W-1:0]   start_ch, done_ch;
   logic [CNT_W-1:0]  rem_q;
   logic [AW-1:0]     cur_pci_q, cur_mem_q;
   logic [AW-1:0]     start_pci, start_mem;

   assign rd_acc = cpu_sel && !cpu_we;
   assign wr_acc = cpu_sel && cpu_we;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         localparam logic [RA_W-1:0] A_CTRL = RA_W'(g * REGS_PER_CH + OFF_CTRL);
         localparam logic [RA_W-1:0] A_PB   = RA_W'(g * REGS_PER_CH + OFF_PBASE);
         localparam logic [RA_W-1:0] A_MB   = RA_W'(g * REGS_PER_CH + OFF_MBASE);

         assign wr_ctrl[g]  = wr_acc && (cpu_addr == A_CTRL);
         assign wr_pbase[g] = wr_acc && (cpu_addr == A_PB);
         assign wr_mbase[g] = wr_acc && (cpu_addr == A_MB);
         assign rd_ctrl[g]  = rd_acc && (cpu_addr == A_CTRL);
         assign set_busy[g] = go_rise[g] && mv_idle;
         assign rd_clear[g] = rd_ctrl[g] && (rem_q == '0);

         bmdma_chan #(.AW(AW), .SIZE_W(SIZE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (wr_ctrl[g]),
            .wr_pbase (wr_pbase[g]),
            .wr_mbase (wr_mbase[g]),
            .wdata    (cpu_wdata),
            .set_busy (set_busy[g]),
            .rd_clear (rd_clear[g]),
            .go_rise  (go_rise[g]),
            .ctrl_q   (ctrl_q[g]),
            .pbase_q  (pbase_q[g]),
            .mbase_q  (mbase_q[g])
         );

         // done flag: set on completion with IE, cleared by write-one
         always_ff @(posedge clk) begin
            if (!rst_n)
               done_flag[g] <= 1'b0;
            else if (mv_done && (done_ch == CH_W'(g)) && ctrl_q[g][CTL_IE])
               done_flag[g] <= 1'b1;
            else if (wr_acc && (cpu_addr == A_DONE) && cpu_wdata[g])
               done_flag[g] <= 1'b0;
         end

         assert_flag_rise_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_flag[g]) |-> $past(mv_done));
         assert_lone_start_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctrl_q[g][CTL_BUSY]) |-> $past(mv_idle));
         assert_busyw_nostart_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl[g] && cpu_wdata[CTL_BUSY] && mv_idle) |=> mv_idle);
      end
   endgenerate

   // the only write in a cycle picks the starting channel
   always_comb begin
      start_ch  = '0;
      start_pci = '0;
      start_mem = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (go_rise[i]) begin
            start_ch  = CH_W'(i);
            start_pci = pbase_q[i];
            start_mem = mbase_q[i];
         end
      end
   end

   assign start = (|go_rise) && mv_idle;

   bmdma_mover #(.AW(AW), .CNT_W(CNT_W), .CH_W(CH_W)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_ch  (start_ch),
      .start_dir (cpu_wdata[CTL_DIR]),
      .start_mio (cpu_wdata[CTL_MIO]),
      .start_pci (start_pci),
      .start_mem (start_mem),
      .start_cnt (cpu_wdata[SIZE_W-1:2]),
      .idle      (mv_idle),
      .done      (mv_done),
      .done_ch   (done_ch),
      .rem_q     (rem_q),
      .cur_pci_q (cur_pci_q),
      .cur_mem_q (cur_mem_q),
      .mem_valid (mem_valid),
      .mem_write (mem_write),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .pci_valid (pci_valid),
      .pci_write (pci_write),
      .pci_io    (pci_io),
      .pci_addr  (pci_addr),
      .pci_wdata (pci_wdata),
      .pci_ready (pci_ready),
      .pci_rdata (pci_rdata)
   );

   // read mux
   always_comb begin
      cpu_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (cpu_addr == RA_W'(i * REGS_PER_CH + OFF_CTRL))  cpu_rdata = ctrl_q[i];
         if (cpu_addr == RA_W'(i * REGS_PER_CH + OFF_PBASE)) cpu_rdata = 32'(pbase_q[i]);
         if (cpu_addr == RA_W'(i * REGS_PER_CH + OFF_MBASE)) cpu_rdata = 32'(mbase_q[i]);
      end
      if (cpu_addr == A_REM)  cpu_rdata = 32'(rem_q);
      if (cpu_addr == A_CMEM) cpu_rdata = 32'(cur_mem_q);
      if (cpu_addr == A_CPCI) cpu_rdata = 32'(cur_pci_q);
      if (cpu_addr == A_DONE) cpu_rdata = 32'(done_flag);
   end
endmodule

// File: tb/bmdma_engine_test.sv
module bmdma_engine_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_sel, cpu_we;
   logic [3:0]  cpu_addr;
   logic [31:0] cpu_wdata, cpu_rdata;
   logic        mem_valid, mem_write, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        pci_valid, pci_write, pci_io, pci_ready;
   logic [31:0] pci_addr, pci_wdata, pci_rdata;
   logic [1:0]  done_flag;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   bmdma_engine uut (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .pci_valid(pci_valid), .pci_write(pci_write), .pci_io(pci_io),
      .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_ready(pci_ready),
      .pci_rdata(pci_rdata), .done_flag(done_flag)
   );

   localparam logic [3:0] A_REM = 4'd6, A_CMEM = 4'd7, A_CPCI = 4'd8, A_DONE = 4'd9;

   typedef struct packed {
      logic        ch;
      logic        dir;
      logic        mio;
      logic        ie;
      logic [19:0] size;
      logic [31:0] pbase;
      logic [31:0] mbase;
      logic [3:0]  stall;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{1'b0, 1'b1, 1'b1, 1'b1, 20'd16, 32'h1000_0040, 32'h0002_0000, 4'd0},
      '{1'b1, 1'b0, 1'b0, 1'b1, 20'd12, 32'h0000_0C00, 32'h0030_0010, 4'd2},
      '{1'b0, 1'b0, 1'b1, 1'b0, 20'd8,  32'h8000_0000, 32'h0000_FFF8, 4'd1},
      '{1'b1, 1'b1, 1'b0, 1'b0, 20'd23, 32'h0000_0100, 32'h0001_0000, 4'd0}
   };

   function automatic logic [31:0] pci_word(input logic [31:0] a);
      return a ^ 32'h5A5A_0F0F;
   endfunction
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return ~a ^ 32'h1234_0000;
   endfunction
   function automatic logic [31:0] ctl(input logic ie, dir, mio, busy, go, input logic [19:0] sz);
      return (32'(busy) << 31) | (32'(ie) << 30) | (32'(dir) << 29) | (32'(go) << 28)
           | (32'(mio) << 25) | 32'(sz);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 0; cpu_we = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      cpu_sel = 1; cpu_we = 0; cpu_addr = a;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 0;
   endtask

   task automatic peek(input logic [3:0] a, output logic [31:0] d);
      cpu_sel = 0; cpu_addr = a;
      #1 d = cpu_rdata;
   endtask

   task automatic serve(input logic dir, input logic mio, input logic [31:0] src,
                        input logic [31:0] dst, input int n, input int stall);
      logic [31:0] v, sa, da, exp;
      for (int w = 0; w < n; w++) begin
         sa = src + 32'(4 * w);
         da = dst + 32'(4 * w);
         for (int k = 0; k < 20 && !(dir ? pci_valid : mem_valid); k++) @(negedge clk);
         if (dir) begin
            chk("R4 pci read valid", 32'(pci_valid), 32'd1);
            chk("R6 pci read addr", pci_addr, sa);
            chk("R4 pci read dir", 32'(pci_write), 32'd0);
            chk("R5 pci space on read", 32'(pci_io), 32'(!mio));
            chk("R6 no write before read data", 32'(mem_valid), 32'd0);
            pci_rdata = pci_word(sa); pci_ready = 1;
            @(negedge clk); pci_ready = 0;
            exp = pci_word(sa);
            chk("R4 mem write valid", 32'(mem_valid), 32'd1);
            chk("R6 mem write addr", mem_addr, da);
            chk("R4 mem write data", mem_wdata, exp);
            chk("R4 mem write dir", 32'(mem_write), 32'd1);
         end else begin
            chk("R4 mem read valid", 32'(mem_valid), 32'd1);
            chk("R6 mem read addr", mem_addr, sa);
            chk("R4 mem read dir", 32'(mem_write), 32'd0);
            chk("R6 no write before read data", 32'(pci_valid), 32'd0);
            mem_rdata = mem_word(sa); mem_ready = 1;
            @(negedge clk); mem_ready = 0;
            exp = mem_word(sa);
            chk("R4 pci write valid", 32'(pci_valid), 32'd1);
            chk("R6 pci write addr", pci_addr, da);
            chk("R4 pci write data", pci_wdata, exp);
            chk("R5 pci space on write", 32'(pci_io), 32'(!mio));
         end
         for (int s = 0; s < stall; s++) begin
            peek(A_REM, v);
            chk("R6 count frozen while write stalls", v, 32'(n - w));
            @(negedge clk);
         end
         if (dir) mem_ready = 1; else pci_ready = 1;
         @(negedge clk);
         mem_ready = 0; pci_ready = 0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c;
      logic [3:0]  cb;
      int          n;
      rst_n = 0; cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
      mem_ready = 0; pci_ready = 0; mem_rdata = 0; pci_rdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      chk("R1 mem_valid", 32'(mem_valid), 32'd0);
      chk("R1 pci_valid", 32'(pci_valid), 32'd0);
      chk("R1 done_flag", 32'(done_flag), 32'd0);
      for (int a = 0; a < 10; a++) begin
         peek(4'(a), v);
         chk("R1 register zero", v, 32'd0);
      end

      // table-driven transfers
      foreach (VECS[i]) begin
         cb = 4'(VECS[i].ch * 3);
         n  = int'(VECS[i].size >> 2);
         wr(cb + 4'd1, VECS[i].pbase);
         wr(cb + 4'd2, VECS[i].mbase);
         peek(cb + 4'd1, v); chk("R10 pci base readback", v, VECS[i].pbase);
         peek(cb + 4'd2, v); chk("R10 mem base readback", v, VECS[i].mbase);
         c = ctl(VECS[i].ie, VECS[i].dir, VECS[i].mio, 1'b0, 1'b1, VECS[i].size);
         wr(cb, c);
         peek(A_REM, v);  chk("R2 count loaded", v, 32'(n));
         peek(A_CPCI, v); chk("R2 pci addr loaded", v, VECS[i].pbase);
         peek(A_CMEM, v); chk("R2 mem addr loaded", v, VECS[i].mbase);
         if (VECS[i].dir)
            serve(1'b1, VECS[i].mio, VECS[i].pbase, VECS[i].mbase, n, int'(VECS[i].stall));
         else
            serve(1'b0, VECS[i].mio, VECS[i].mbase, VECS[i].pbase, n, int'(VECS[i].stall));
         @(negedge clk);
         peek(A_REM, v);  chk("R6 count ends at zero", v, 32'd0);
         peek(A_CPCI, v); chk("R6 pci addr advanced", v, VECS[i].pbase + 32'(4 * n));
         peek(A_CMEM, v); chk("R6 mem addr advanced", v, VECS[i].mbase + 32'(4 * n));
         chk("R6 idle after last word", 32'(mem_valid | pci_valid), 32'd0);
         chk("R9 done flag", 32'(done_flag[VECS[i].ch]), 32'(VECS[i].ie));
         rd(cb, v); chk("R7 ctrl before clear", v, c | 32'h8000_0000);
         rd(cb, v); chk("R7 busy and go cleared", v, c & ~32'h1000_0000);
         wr(A_DONE, 32'h3);
         chk("R9 write-one clears flag", 32'(done_flag), 32'd0);
      end

      // R3: busy bit in written value, then GO already set
      wr(4'd0, ctl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 20'd8));
      @(negedge clk);
      chk("R3 busy in write blocks start", 32'(mem_valid | pci_valid), 32'd0);
      peek(A_REM, v); chk("R3 count untouched", v, 32'd0);
      wr(4'd0, ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'd8));
      @(negedge clk);
      chk("R3 GO already set blocks start", 32'(mem_valid | pci_valid), 32'd0);
      rd(4'd0, v); chk("R3 busy stays clear", v, ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'd8));

      // R8 / R7: second channel ignored while first runs
      wr(4'd1, 32'h0000_4000);
      wr(4'd2, 32'h0000_8000);
      wr(4'd0, ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 20'd8));
      wr(4'd3, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'd4));
      peek(A_REM, v);  chk("R8 count kept by running channel", v, 32'd2);
      peek(A_CPCI, v); chk("R8 pci addr kept by running channel", v, 32'h0000_4000);
      rd(4'd3, v); chk("R8 other channel not busy", v, ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'd4));
      rd(4'd0, v); chk("R7 read mid-transfer", v, ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 20'd8));
      rd(4'd0, v); chk("R7 no clear while count nonzero", v, ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 20'd8));
      serve(1'b1, 1'b1, 32'h0000_4000, 32'h0000_8000, 2, 0);
      repeat (2) @(negedge clk);
      chk("R8 no late start of ignored channel", 32'(mem_valid | pci_valid), 32'd0);
      chk("R9 flag of running channel only", 32'(done_flag), 32'd1);
      rd(4'd3, v);
      rd(4'd0, v);
      rd(4'd0, v); chk("R7 cleared after completion", v, ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'd8));
      wr(A_DONE, 32'h1);

      // R2 / R9: size below one word
      wr(4'd3, ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'd3));
      repeat (2) @(negedge clk);
      chk("R2 zero-word no access", 32'(mem_valid | pci_valid), 32'd0);
      chk("R9 zero-word done flag", 32'(done_flag), 32'd2);
      rd(4'd3, v); chk("R2 zero-word busy set", v, ctl(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 20'd3));
      wr(A_DONE, 32'h2);
      chk("R9 flag cleared", 32'(done_flag), 32'd0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule